// File: doc/BRIEF.md
# Fixed-Window Stack Pointer Unit

This block is the stack pointer of a small 8-bit processor core. The stack sits in a 64-byte window at the top of page zero. The pointer is 16 bits wide as the processor sees it, but only its low six bits are stored. The upper ten bits are tied to the window base, so every stack address falls between $00C0 and $00FF. The pointer always names the next free byte. A push writes there and then steps down. A pull steps up and then reads. When either move runs past an end of the window, the pointer wraps to the other end without raising any error, and older stacked data is simply overwritten.

On top of single pushes and pulls, the unit runs multi-byte frames. A subroutine call is two pushed bytes and an interrupt entry is five, one byte per clock. For each byte the unit gives the stack address, a write/read flag and a slot number. The surrounding datapath uses the slot number to choose which register value goes onto the bus. While a frame is still in progress, a busy flag is raised and all new commands are dropped. A reset-pointer command returns the pointer to $00FF. Memory and the stacked data are outside this block.

Every access appears on the outputs one clock after the command edge, as a one-cycle strobe on `acc_vld_o`.

Top module: `stk_ptr_unit`

## Requirements
- R1: During and after a synchronous active-low reset, `sp_o` reads $00FF, `acc_vld_o` is 0 and `busy_o` is 0.
- R2: A reset-pointer command (`rsp_i`) accepted at an edge makes `sp_o` read $00FF after that edge, and it causes no memory access.
- R3: An accepted push writes at the current `sp_o` address with slot 0 (`acc_wr_o`=1), and after that `sp_o` is one lower.
- R4: An accepted pull first raises the pointer by one and then reads at the new address (`acc_wr_o`=0, slot 0), so after the pull `sp_o` equals the read address.
- R5: Every access address and every `sp_o` value has its upper ten bits equal to 0000000011. A push at $00C0 leaves `sp_o` at $00FF, and a pull from $00FF reads $00C0.
- R6: An accepted call produces two write accesses on consecutive cycles at descending addresses, with slot 0 (return address low byte) followed by slot 1 (high byte). `busy_o` is 1 only while the first byte is on the outputs.
- R7: An accepted interrupt produces five write accesses on consecutive cycles at descending addresses. The slots run 0 to 4, carrying return-address low byte, return-address high byte, index, accumulator and condition codes in that order. `busy_o` is 1 while each of the first four bytes is on the outputs.
- R8: Any command present at an edge where `busy_o` is 1 is ignored. The frame goes on unchanged, and nothing else happens to the pointer or the access stream.
- R9: When push and pull are both asserted with no higher-priority command present, nothing happens: there is no access and `sp_o` stays the same.
- R10: When several commands are present at an idle edge, they are served in the order reset-pointer, then interrupt, then call, then push/pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push one byte |
| pull_i | input | 1 | Pull one byte |
| rsp_i | input | 1 | Reset the stack pointer to the window top |
| call_i | input | 1 | Start a two-byte call frame |
| irq_i | input | 1 | Start a five-byte interrupt frame |
| acc_vld_o | output | 1 | A stack access is presented this cycle |
| acc_addr_o | output | 16 | Stack memory address of the access |
| acc_wr_o | output | 1 | 1 for a write (push), 0 for a read (pull) |
| slot_o | output | 3 | Byte index within the current frame |
| busy_o | output | 1 | More frame bytes follow; commands are ignored |
| sp_o | output | 16 | Current architectural stack pointer |

## Verification
The bench uses the default parameters: six live pointer bits under a $00C0 base, a two-byte call and a five-byte interrupt. A window of only 64 bytes means that a few thousand random cycles, biased towards pushes in one phase and towards pulls in another, cross both wrap edges many times. Because the same random draws also raise commands while a frame is busy, the discard rule and the priority order are both exercised. A directed opening covers reset, a pull straight out of $00FF, and a full lap of 65 pushes.

// File: rtl/stk_pkg.sv
// Package: shared types for the stack pointer unit.
// Assumes: one decoded operation per clock, chosen by fixed priority.
package stk_pkg;

    // Operation chosen at an edge once priority and busy are applied
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_RSP  = 3'd1,
        OP_PUSH = 3'd2,
        OP_PULL = 3'd3,
        OP_CALL = 3'd4,
        OP_IRQ  = 3'd5
    } stk_op_e;

endpackage

// File: rtl/stk_cmd_dec.sv
// Module: stk_cmd_dec
// Turns the raw command lines into a single operation. The priority is
// reset-pointer, interrupt, call, then push/pull. Push and pull together
// cancel each other. While a frame is busy every command is dropped.
// Assumes: the command lines are synchronous to the unit's clock.
module stk_cmd_dec
    import stk_pkg::*;
(
    input  logic    busy_i,
    input  logic    push_i,
    input  logic    pull_i,
    input  logic    rsp_i,
    input  logic    call_i,
    input  logic    irq_i,
    output stk_op_e op_o
);

    // Priority select of the operation that is accepted this cycle
    always_comb begin
        op_o = OP_NONE;
        if (!busy_i) begin
            if (rsp_i)                  op_o = OP_RSP;
            else if (irq_i)             op_o = OP_IRQ;
            else if (call_i)            op_o = OP_CALL;
            else if (push_i && !pull_i) op_o = OP_PUSH;
            else if (pull_i && !push_i) op_o = OP_PULL;
            else                        op_o = OP_NONE;
        end
    end

endmodule

// File: rtl/stk_frame_seq.sv
// Module: stk_frame_seq
// Counts the bytes of a call or interrupt frame that are still to be
// issued and supplies the slot number for each continuation byte. The
// first byte of a frame is issued in the same cycle the frame is accepted,
// so this block only tracks the remaining bytes.
// Assumes: CALL_LEN and IRQ_LEN are at least 1 and fit in SLOT_W bits.
module stk_frame_seq
    import stk_pkg::*;
#(
    parameter int CALL_LEN = 2,
    parameter int IRQ_LEN  = 5,
    parameter int SLOT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  stk_op_e           op_i,
    output logic              cont_o,
    output logic [SLOT_W-1:0] slot_o
);

    localparam logic [SLOT_W-1:0] CALL_REM = SLOT_W'(CALL_LEN - 1);
    localparam logic [SLOT_W-1:0] IRQ_REM  = SLOT_W'(IRQ_LEN - 1);
    localparam logic [SLOT_W-1:0] ONE      = SLOT_W'(1);

    logic [SLOT_W-1:0] rem_q;
    logic [SLOT_W-1:0] slot_q;

    assign cont_o = (rem_q != '0);
    assign slot_o = slot_q;

    // Load the remaining count at frame start, count down per byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            slot_q <= '0;
        end else if (cont_o) begin
            rem_q  <= rem_q - ONE;
            slot_q <= slot_q + ONE;
        end else if (op_i == OP_CALL) begin
            rem_q  <= CALL_REM;
            slot_q <= ONE;
        end else if (op_i == OP_IRQ) begin
            rem_q  <= IRQ_REM;
            slot_q <= ONE;
        end
    end

endmodule

// File: rtl/stk_ptr_reg.sv
// Module: stk_ptr_reg
// Holds the live low bits of the stack pointer. Each step wraps modulo
// the window size. A load sets every live bit to one, which is the
// window top.
// Assumes: at most one of load, dec and inc is high in any cycle.
module stk_ptr_reg #(
    parameter int LIVE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_top_i,
    input  logic              dec_i,
    input  logic              inc_i,
    output logic [LIVE_W-1:0] sp_o,
    output logic [LIVE_W-1:0] sp_up_o
);

    localparam logic [LIVE_W-1:0] STEP = LIVE_W'(1);

    logic [LIVE_W-1:0] sp_q;

    assign sp_o    = sp_q;
    assign sp_up_o = sp_q + STEP;

    // Pointer update with silent wrap inside the window
    always_ff @(posedge clk) begin
        if (!rst_n)          sp_q <= '1;
        else if (load_top_i) sp_q <= '1;
        else if (dec_i)      sp_q <= sp_q - STEP;
        else if (inc_i)      sp_q <= sp_up_o;
    end

endmodule

// File: rtl/stk_ptr_unit.sv
// Module: stk_ptr_unit (top)
// Stack pointer for a small processor. It forms page-zero window
// addresses, steps the pointer for pushes and pulls, and sequences
// call and interrupt frames one byte per clock. Access outputs are
// registered and appear one clock after the accepting edge.
// Assumes: the WIN_BASE bits below LIVE_W are zero.
module stk_ptr_unit
    import stk_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter int              LIVE_W   = 6,
    parameter logic [15:0]     WIN_BASE = 16'h00C0,
    parameter int              CALL_LEN = 2,
    parameter int              IRQ_LEN  = 5,
    parameter int              SLOT_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pull_i,
    input  logic              rsp_i,
    input  logic              call_i,
    input  logic              irq_i,
    output logic              acc_vld_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              acc_wr_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              busy_o,
    output logic [ADDR_W-1:0] sp_o
);

    localparam int HI_W = ADDR_W - LIVE_W;
    localparam logic [HI_W-1:0] HI_BITS = WIN_BASE[ADDR_W-1:LIVE_W];

    stk_op_e           op;
    logic              cont;
    logic [SLOT_W-1:0] seq_slot;
    logic [LIVE_W-1:0] sp_cur;
    logic [LIVE_W-1:0] sp_up;
    logic              do_wr;
    logic              do_rd;

    logic              vld_q;
    logic [ADDR_W-1:0] addr_q;
    logic              wr_q;
    logic [SLOT_W-1:0] slot_q;

    stk_cmd_dec u_dec (
        .busy_i (cont),
        .push_i (push_i),
        .pull_i (pull_i),
        .rsp_i  (rsp_i),
        .call_i (call_i),
        .irq_i  (irq_i),
        .op_o   (op)
    );

    stk_frame_seq #(
        .CALL_LEN (CALL_LEN),
        .IRQ_LEN  (IRQ_LEN),
        .SLOT_W   (SLOT_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .op_i   (op),
        .cont_o (cont),
        .slot_o (seq_slot)
    );

    stk_ptr_reg #(
        .LIVE_W (LIVE_W)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_top_i (op == OP_RSP),
        .dec_i      (do_wr),
        .inc_i      (do_rd),
        .sp_o       (sp_cur),
        .sp_up_o    (sp_up)
    );

    // Classify this cycle's access: frame bytes and pushes write, pulls read
    always_comb begin
        do_wr = cont || (op == OP_PUSH) || (op == OP_CALL) || (op == OP_IRQ);
        do_rd = (op == OP_PULL);
    end

    // Register the access strobe, address, direction and slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
            wr_q   <= 1'b0;
            slot_q <= '0;
        end else begin
            vld_q  <= do_wr || do_rd;
            addr_q <= {HI_BITS, (do_rd ? sp_up : sp_cur)};
            wr_q   <= do_wr;
            slot_q <= cont ? seq_slot : '0;
        end
    end

    assign acc_vld_o  = vld_q;
    assign acc_addr_o = addr_q;
    assign acc_wr_o   = wr_q;
    assign slot_o     = slot_q;
    assign busy_o     = cont;
    assign sp_o       = {HI_BITS, sp_cur};

endmodule

// File: rtl/stk_ptr_unit_chk.sv
// Module: stk_ptr_unit_chk
// Property checker for stk_ptr_unit, attached through bind. It looks
// only at the top-level ports.
module stk_ptr_unit_chk #(
    parameter int          ADDR_W   = 16,
    parameter int          LIVE_W   = 6,
    parameter logic [15:0] WIN_BASE = 16'h00C0,
    parameter int          SLOT_W   = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              push_i,
    input logic              pull_i,
    input logic              rsp_i,
    input logic              call_i,
    input logic              irq_i,
    input logic              acc_vld_o,
    input logic [ADDR_W-1:0] acc_addr_o,
    input logic              acc_wr_o,
    input logic [SLOT_W-1:0] slot_o,
    input logic              busy_o,
    input logic [ADDR_W-1:0] sp_o
);

    localparam int HI_W = ADDR_W - LIVE_W;
    localparam logic [HI_W-1:0] HI_BITS = WIN_BASE[ADDR_W-1:LIVE_W];
    localparam logic [ADDR_W-1:0] TOP = {HI_BITS, {LIVE_W{1'b1}}};

    logic [LIVE_W-1:0] below_acc;
    logic [SLOT_W-1:0] slot_nx;
    assign below_acc = acc_addr_o[LIVE_W-1:0] - LIVE_W'(1);
    assign slot_nx   = slot_o + SLOT_W'(1);

    // R5: access addresses stay inside the window
    a_r5_addr_window: assert property (@(posedge clk) disable iff (!rst_n)
        acc_vld_o |-> acc_addr_o[ADDR_W-1:LIVE_W] == HI_BITS);

    // R5: pointer stays inside the window
    a_r5_sp_window: assert property (@(posedge clk) disable iff (!rst_n)
        sp_o[ADDR_W-1:LIVE_W] == HI_BITS);

    // R3: after a write the pointer sits one below the written address
    a_r3_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_o && acc_wr_o) |-> sp_o[LIVE_W-1:0] == below_acc);

    // R4: after a read the pointer equals the read address
    a_r4_pull_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld_o && !acc_wr_o) |-> sp_o == acc_addr_o);

    // R8: while busy, the next cycle carries the next frame byte
    a_r8_frame_next: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (acc_vld_o && acc_wr_o && slot_o == $past(slot_nx)));

    // R2: an idle reset-pointer command lands the pointer at the top
    a_r2_rsp_top: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_i && !busy_o) |=> (sp_o == TOP && !acc_vld_o));

    // R9: simultaneous push and pull with nothing else is a no-op
    a_r9_push_pull_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pull_i && !rsp_i && !irq_i && !call_i && !busy_o)
        |=> (!acc_vld_o && $stable(sp_o)));

endmodule

bind stk_ptr_unit stk_ptr_unit_chk #(
    .ADDR_W   (ADDR_W),
    .LIVE_W   (LIVE_W),
    .WIN_BASE (WIN_BASE),
    .SLOT_W   (SLOT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push_i),
    .pull_i     (pull_i),
    .rsp_i      (rsp_i),
    .call_i     (call_i),
    .irq_i      (irq_i),
    .acc_vld_o  (acc_vld_o),
    .acc_addr_o (acc_addr_o),
    .acc_wr_o   (acc_wr_o),
    .slot_o     (slot_o),
    .busy_o     (busy_o),
    .sp_o       (sp_o)
);

// File: tb/stk_ptr_unit_tb_top.sv
`timescale 1ns/1ps
// Bench for stk_ptr_unit: a directed opening followed by seeded random
// commands, all compared against a behavioural model in the bench.
module stk_ptr_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0, pull_i = 1'b0, rsp_i = 1'b0, call_i = 1'b0, irq_i = 1'b0;
    logic        acc_vld_o, acc_wr_o, busy_o;
    logic [15:0] acc_addr_o, sp_o;
    logic [2:0]  slot_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // model state and expected outputs
    logic [5:0]  m_sp = 6'h3F;
    int          m_rem = 0;
    int          m_slot = 0;
    logic        e_vld = 0, e_wr = 0, e_busy = 0;
    logic [15:0] e_addr = 16'h0000, e_sp = 16'h00FF;
    int          e_slot = 0;
    string       e_tag = "R1";

    always #2 clk = ~clk;

    stk_ptr_unit dut_i (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pull_i(pull_i),
        .rsp_i(rsp_i), .call_i(call_i), .irq_i(irq_i),
        .acc_vld_o(acc_vld_o), .acc_addr_o(acc_addr_o), .acc_wr_o(acc_wr_o),
        .slot_o(slot_o), .busy_o(busy_o), .sp_o(sp_o)
    );

    function automatic logic [15:0] win(input logic [5:0] lo);
        return {10'b0000000011, lo};
    endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // compare the outputs against the model's prediction
    task automatic check_now();
        chk(e_tag, "acc_vld", int'(acc_vld_o), int'(e_vld));
        chk(e_tag, "busy", int'(busy_o), int'(e_busy));
        chk(e_tag, "sp", int'(sp_o), int'(e_sp));
        if (e_vld) begin
            chk(e_tag, "addr", int'(acc_addr_o), int'(e_addr));
            chk(e_tag, "wr", int'(acc_wr_o), int'(e_wr));
            chk(e_tag, "slot", int'(slot_o), e_slot);
        end
    endtask

    // predict what the next edge produces for these inputs
    task automatic model(input bit p, input bit q, input bit r, input bit c, input bit i);
        e_vld = 0;
        if (m_rem > 0) begin
            e_tag = "R8";
            e_vld = 1; e_wr = 1; e_addr = win(m_sp); e_slot = m_slot;
            m_sp = m_sp - 6'd1; m_rem--; m_slot++;
        end else if (r) begin
            e_tag = (i || c || p || q) ? "R10" : "R2";
            m_sp = 6'h3F;
        end else if (i || c) begin
            e_tag = i ? ((c || p || q) ? "R10" : "R7") : ((p || q) ? "R10" : "R6");
            e_vld = 1; e_wr = 1; e_addr = win(m_sp); e_slot = 0;
            m_sp = m_sp - 6'd1; m_rem = i ? 4 : 1; m_slot = 1;
        end else if (p && q) begin
            e_tag = "R9";
        end else if (p) begin
            e_tag = (m_sp == 6'h00) ? "R5" : "R3";
            e_vld = 1; e_wr = 1; e_addr = win(m_sp); e_slot = 0;
            m_sp = m_sp - 6'd1;
        end else if (q) begin
            e_tag = (m_sp == 6'h3F) ? "R5" : "R4";
            m_sp = m_sp + 6'd1;
            e_vld = 1; e_wr = 0; e_addr = win(m_sp); e_slot = 0;
        end else begin
            e_tag = "R3";
        end
        e_busy = (m_rem > 0);
        e_sp = win(m_sp);
    endtask

    // one cycle: check the previous result, then apply new inputs
    task automatic cyc(input bit p, input bit q, input bit r, input bit c, input bit i);
        @(negedge clk);
        check_now();
        push_i = p; pull_i = q; rsp_i = r; call_i = c; irq_i = i;
        model(p, q, r, c, i);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        // R1: reset state, checked while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "sp in reset", int'(sp_o), 16'h00FF);
        chk("R1", "vld in reset", int'(acc_vld_o), 0);
        chk("R1", "busy in reset", int'(busy_o), 0);
        rst_n = 1'b1;
        e_tag = "R1";
        // R5: pull straight from the top wraps to $00C0
        cyc(0, 1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);   // R2 back to the top
        // R5: a full lap of pushes wraps past $00C0
        for (int k = 0; k < 65; k++) cyc(1, 0, 0, 0, 0);
        // R7 then R8: interrupt with commands hammering during the frame
        cyc(0, 0, 0, 0, 1);
        for (int k = 0; k < 4; k++) cyc(1, 0, 1, 1, 1);
        // R6 then R10: call, then all commands at once
        cyc(0, 0, 0, 1, 0);
        cyc(0, 1, 0, 0, 0);
        cyc(1, 1, 1, 1, 1);
        cyc(1, 1, 0, 0, 0);   // R9
        // random phases: push-biased, then pull-biased
        for (int ph = 0; ph < 4; ph++) begin
            for (int k = 0; k < 800; k++) begin
                int unsigned v;
                bit p, q;
                v = $urandom % 100;
                p = (ph % 2 == 0) ? (v < 55) : (v < 20);
                q = (ph % 2 == 0) ? (v >= 45 && v < 65) : (v >= 15 && v < 75);
                cyc(p, q, ($urandom % 60) == 0, ($urandom % 25) == 0, ($urandom % 30) == 0);
            end
        end
        cyc(0, 0, 0, 0, 0);
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 0);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule